// File: doc/BRIEF.md
# Angle PWM Frame Encoder

This block turns an angle word into a pulse-width-modulated frame of fixed length on a single output line. Time is counted in tick periods: the block advances only on clock cycles where the tick enable is high, so the frame rate is set entirely by whoever generates the tick (typically one tick every few hundred nanoseconds). Each frame opens with a high preamble, continues with a data section whose leading high part is as long as the angle value, and closes with a short low tail.

A receiver measures the high time of a frame to recover the angle. The preamble is split into an initialisation part that is always high and a flag part that is high only while no error is reported. On an error the flag part and the whole data section go low, so a faulty source is recognised by a frame whose only high time is the shortened preamble. The angle and the error flag are captured once per frame, at its first tick, so a frame always carries one consistent value. With the default 12-bit angle, a frame lasts 12 + 4 + 4095 + 8 = 4119 tick periods.

Top module: `apwm_frame_enc`

## Requirements
- R1: While rst_ni is low or en_i is low, pwm_o is low one clock later and the frame position is cleared; after enabling, pwm_o stays low until the first tick, and that tick starts a frame at period 0.
- R2: A frame lasts INIT_LEN + FLAG_LEN + (2^ANGLE_W − 1) + TAIL_LEN tick periods (4119 by default), and a new frame follows the last period of the previous one without a gap.
- R3: Periods 0 to INIT_LEN−1 of every frame (0 to 11 by default) are high, with or without an error.
- R4: The FLAG_LEN periods after the initialisation part (12 to 15 by default) are high when the captured error flag is 0 and low when it is 1.
- R5: With no error, the 2^ANGLE_W − 1 data periods that follow are high for the first N of them, N being the captured angle, and low for the rest; angle 0 gives an all-low data section and the largest angle an all-high one.
- R6: With the captured error flag at 1, every data period is low.
- R7: The last TAIL_LEN periods of every frame (8 by default) are low.
- R8: angle_i and err_i are sampled on the tick that starts a frame; changes during the rest of the frame have no effect on that frame.
- R9: pwm_o changes only on a clock edge where tick_i is high; a tick while en_i is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Tick enable; one pulse marks one PWM period |
| en_i | input | 1 | Encoder enable; low holds the output low and the frame position at 0 |
| angle_i | input | ANGLE_W | Angle to encode, captured at each frame start |
| err_i | input | 1 | Error flag, captured at each frame start |
| pwm_o | output | 1 | Registered PWM frame output |

## Verification
A reduced configuration with a 4-bit angle is swept over every angle value with the error flag both clear and set, in back-to-back frames, and every tick period is compared with a period-by-period model; the clear/set pairs separate the flag part and data section from the always-high initialisation part, and the angle sweep covers the empty and full data sections at its ends. Inputs are scrambled a few ticks into each frame, which tells a per-frame capture apart from continuous sampling, and idle cycles between ticks show that the output only moves on a tick. A disable in the middle of a frame, a tick while disabled and a restart separate a true restart from a resumed frame, and one full frame at the default width checks the overall length and high time for a mid-range angle.

// File: rtl/apwm_pkg.sv
package apwm_pkg;

    // Section of the frame a tick period falls in
    typedef enum logic [1:0] {
        SEC_INIT = 2'd0,
        SEC_FLAG = 2'd1,
        SEC_DATA = 2'd2,
        SEC_TAIL = 2'd3
    } apwm_sec_e;

endpackage

// File: rtl/apwm_sequencer.sv
module apwm_sequencer #(
    parameter int ANGLE_W   = 12,
    parameter int FRAME_LEN = 4119,
    parameter int POS_W     = 13
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic               tick_i,
    input  logic [ANGLE_W-1:0] angle_i,
    input  logic               err_i,
    output logic               nxt_started_o,
    output logic [POS_W-1:0]   nxt_pos_o,
    output logic [ANGLE_W-1:0] nxt_ang_o,
    output logic               nxt_err_o,
    output logic               cur_started_o,
    output logic [POS_W-1:0]   cur_pos_o,
    output logic [ANGLE_W-1:0] cur_ang_o,
    output logic               cur_err_o
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic               started;
        logic [POS_W-1:0]   pos;
        logic [ANGLE_W-1:0] ang;
        logic               err;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!en_i) begin
            seq_d.started = 1'b0;
            seq_d.pos     = '0;
        end else if (tick_i) begin
            if (!seq_q.started || seq_q.pos == LAST_POS) begin
                // frame boundary: capture the inputs for the whole frame
                seq_d.started = 1'b1;
                seq_d.pos     = '0;
                seq_d.ang     = angle_i;
                seq_d.err     = err_i;
            end else begin
                seq_d.pos = seq_q.pos + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign nxt_started_o = seq_d.started;
    assign nxt_pos_o     = seq_d.pos;
    assign nxt_ang_o     = seq_d.ang;
    assign nxt_err_o     = seq_d.err;
    assign cur_started_o = seq_q.started;
    assign cur_pos_o     = seq_q.pos;
    assign cur_ang_o     = seq_q.ang;
    assign cur_err_o     = seq_q.err;

endmodule

// File: rtl/apwm_section_decode.sv
module apwm_section_decode
    import apwm_pkg::*;
#(
    parameter int POS_W    = 13,
    parameter int INIT_LEN = 12,
    parameter int FLAG_LEN = 4,
    parameter int DATA_LEN = 4095
) (
    input  logic [POS_W-1:0] pos_i,
    output apwm_sec_e        sec_o,
    output logic [POS_W-1:0] off_o
);

    localparam int DATA_START = INIT_LEN + FLAG_LEN;
    localparam int TAIL_START = DATA_START + DATA_LEN;

    always_comb begin
        if (pos_i < POS_W'(INIT_LEN)) begin
            sec_o = SEC_INIT;
        end else if (pos_i < POS_W'(DATA_START)) begin
            sec_o = SEC_FLAG;
        end else if (pos_i < POS_W'(TAIL_START)) begin
            sec_o = SEC_DATA;
        end else begin
            sec_o = SEC_TAIL;
        end
        // offset into the data section, meaningful only there
        off_o = pos_i - POS_W'(DATA_START);
    end

endmodule

// File: rtl/apwm_level.sv
module apwm_level
    import apwm_pkg::*;
#(
    parameter int ANGLE_W = 12,
    parameter int POS_W   = 13
) (
    input  apwm_sec_e          sec_i,
    input  logic [POS_W-1:0]   off_i,
    input  logic [ANGLE_W-1:0] ang_i,
    input  logic               err_i,
    output logic               level_o
);

    logic [POS_W-1:0] ang_ext;

    always_comb begin
        ang_ext = POS_W'(ang_i);
        unique case (sec_i)
            SEC_INIT: level_o = 1'b1;
            SEC_FLAG: level_o = !err_i;
            SEC_DATA: level_o = !err_i && (off_i < ang_ext);
            default:  level_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/apwm_frame_enc.sv
module apwm_frame_enc
    import apwm_pkg::*;
#(
    parameter int ANGLE_W  = 12,
    parameter int INIT_LEN = 12,
    parameter int FLAG_LEN = 4,
    parameter int TAIL_LEN = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               tick_i,
    input  logic               en_i,
    input  logic [ANGLE_W-1:0] angle_i,
    input  logic               err_i,
    output logic               pwm_o
);

    localparam int DATA_LEN  = (1 << ANGLE_W) - 1;
    localparam int FRAME_LEN = INIT_LEN + FLAG_LEN + DATA_LEN + TAIL_LEN;
    localparam int POS_W     = $clog2(FRAME_LEN);

    logic               nxt_started, seq_started;
    logic [POS_W-1:0]   nxt_pos, seq_pos;
    logic [ANGLE_W-1:0] nxt_ang, seq_ang;
    logic               nxt_err, seq_err;
    apwm_sec_e          nxt_sec;
    logic [POS_W-1:0]   nxt_off;
    logic               nxt_level;
    logic               pwm_d, pwm_q;

    apwm_sequencer #(
        .ANGLE_W   (ANGLE_W),
        .FRAME_LEN (FRAME_LEN),
        .POS_W     (POS_W)
    ) u_seq (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .en_i          (en_i),
        .tick_i        (tick_i),
        .angle_i       (angle_i),
        .err_i         (err_i),
        .nxt_started_o (nxt_started),
        .nxt_pos_o     (nxt_pos),
        .nxt_ang_o     (nxt_ang),
        .nxt_err_o     (nxt_err),
        .cur_started_o (seq_started),
        .cur_pos_o     (seq_pos),
        .cur_ang_o     (seq_ang),
        .cur_err_o     (seq_err)
    );

    apwm_section_decode #(
        .POS_W    (POS_W),
        .INIT_LEN (INIT_LEN),
        .FLAG_LEN (FLAG_LEN),
        .DATA_LEN (DATA_LEN)
    ) u_dec (
        .pos_i (nxt_pos),
        .sec_o (nxt_sec),
        .off_o (nxt_off)
    );

    apwm_level #(
        .ANGLE_W (ANGLE_W),
        .POS_W   (POS_W)
    ) u_lvl (
        .sec_i   (nxt_sec),
        .off_i   (nxt_off),
        .ang_i   (nxt_ang),
        .err_i   (nxt_err),
        .level_o (nxt_level)
    );

    // output level for the period the next state describes
    always_comb begin
        pwm_d = nxt_started && nxt_level;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= pwm_d;
        end
    end

    assign pwm_o = pwm_q;

endmodule

// File: rtl/apwm_frame_chk.sv
module apwm_frame_chk #(
    parameter int ANGLE_W  = 12,
    parameter int INIT_LEN = 12,
    parameter int FLAG_LEN = 4,
    parameter int TAIL_LEN = 8,
    parameter int POS_W    = 13
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               tick_i,
    input logic               en_i,
    input logic               pwm_o,
    input logic               seq_started,
    input logic [POS_W-1:0]   seq_pos,
    input logic [ANGLE_W-1:0] seq_ang,
    input logic               seq_err
);

    localparam int FRAME_LEN = INIT_LEN + FLAG_LEN + ((1 << ANGLE_W) - 1) + TAIL_LEN;
    localparam logic [POS_W-1:0] LAST_POS   = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0] INIT_END   = POS_W'(INIT_LEN);
    localparam logic [POS_W-1:0] TAIL_START = POS_W'(FRAME_LEN - TAIL_LEN);

    AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!pwm_o && seq_pos == '0)); // R1

    AST_POS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_pos <= LAST_POS); // R2

    AST_INIT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_started && seq_pos < INIT_END) |-> pwm_o); // R3

    AST_ERR_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_started && seq_err && seq_pos >= INIT_END) |-> !pwm_o); // R6

    AST_TAIL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_started && seq_pos >= TAIL_START) |-> !pwm_o); // R7

    AST_CAPTURE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_started && !(en_i && tick_i && seq_pos == LAST_POS))
            |=> ($stable(seq_ang) && $stable(seq_err))); // R8

    AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !tick_i) |=> $stable(pwm_o)); // R9

endmodule

bind apwm_frame_enc apwm_frame_chk #(
    .ANGLE_W  (ANGLE_W),
    .INIT_LEN (INIT_LEN),
    .FLAG_LEN (FLAG_LEN),
    .TAIL_LEN (TAIL_LEN),
    .POS_W    (POS_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .en_i        (en_i),
    .pwm_o       (pwm_o),
    .seq_started (seq_started),
    .seq_pos     (seq_pos),
    .seq_ang     (seq_ang),
    .seq_err     (seq_err)
);

// File: tb/sim_apwm_frame_enc.sv
module sim_apwm_frame_enc;

    // reduced configuration for the exhaustive sweep
    localparam int BA  = 4;
    localparam int BI  = 12;
    localparam int BF  = 4;
    localparam int BT  = 8;
    localparam int BD  = (1 << BA) - 1;
    localparam int BFR = BI + BF + BD + BT;
    // default configuration for the full-length frame
    localparam int FA  = 12;
    localparam int FD  = (1 << FA) - 1;
    localparam int FFR = BI + BF + FD + BT;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          en = 1'b0;
    logic          err = 1'b0;
    logic [BA-1:0] ang = '0;
    logic          pwm;

    logic          en1 = 1'b0;
    logic          tick1 = 1'b0;
    logic [FA-1:0] ang1 = 12'd1000;
    logic          pwm1;

    int total = 0;
    int bad   = 0;
    int k     = -1;
    int la    = 0;
    bit le    = 1'b0;

    always #5 clk = ~clk;

    apwm_frame_enc #(.ANGLE_W(BA), .INIT_LEN(BI), .FLAG_LEN(BF), .TAIL_LEN(BT)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .en_i(en),
        .angle_i(ang), .err_i(err), .pwm_o(pwm)
    );

    apwm_frame_enc u1 (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick1), .en_i(en1),
        .angle_i(ang1), .err_i(1'b0), .pwm_o(pwm1)
    );

    function automatic bit lvl(int p, int a, bit e);
        if (p < 0)            return 1'b0;
        if (p < BI)           return 1'b1;
        if (p < BI + BF)      return !e;
        if (p < BI + BF + BD) return !e && ((p - BI - BF) < a);
        return 1'b0;
    endfunction

    function automatic string tag(int p, bit e);
        if (p < 0)            return "R1";
        if (p == 0)           return "R2";
        if (p < BI)           return "R3";
        if (p < BI + BF)      return "R4";
        if (p < BI + BF + BD) return e ? "R6" : "R5";
        return "R7";
    endfunction

    task automatic chk(input logic act, input bit exp, input string r);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b (period %0d)", r, act, exp, k);
        end
    endtask

    // one tick pulse, model update, then sample after the edge
    task automatic step_tick(input string r_over);
        @(negedge clk);
        tick = 1'b1;
        if (en) begin
            if (k < 0 || k == BFR - 1) begin
                k  = 0;
                la = int'(ang);
                le = err;
            end else begin
                k++;
            end
        end
        @(negedge clk);
        tick = 1'b0;
        chk(pwm, lvl(k, la, le), (r_over != "") ? r_over : tag(k, le));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pwm, 1'b0, "R1");
        chk(pwm1, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        en = 1'b1;
        repeat (3) @(negedge clk);
        chk(pwm, 1'b0, "R1");   // enabled, no tick yet

        // exhaustive sweep: every angle, error clear and set, back to back
        for (int a = 0; a < (1 << BA); a++) begin
            for (int e = 0; e < 2; e++) begin
                for (int t = 0; t < BFR; t++) begin
                    if (t == 0) begin
                        ang = BA'(a);
                        err = e[0];
                    end
                    step_tick("");
                    if (t == 3) begin
                        ang = ~BA'(a);     // R8: ignored until next frame
                        err = !e[0];
                    end
                    if (t == 20) begin
                        @(negedge clk);    // idle cycle without tick
                        chk(pwm, lvl(k, la, le), "R9");
                    end
                end
            end
        end

        // disable mid-frame, tick while disabled, restart at period 0
        ang = 4'd9;
        err = 1'b0;
        repeat (5) step_tick("");
        @(negedge clk);
        en = 1'b0;
        k  = -1;
        @(negedge clk);
        chk(pwm, 1'b0, "R1");
        step_tick("R9");
        ang = 4'd7;
        @(negedge clk);
        en = 1'b1;
        for (int t = 0; t < BFR + 2; t++) begin
            step_tick((t == 0) ? "R1" : "");
        end

        // full default frame, tick every cycle
        @(negedge clk);
        en1   = 1'b1;
        tick1 = 1'b1;
        begin
            int hi;
            hi = 0;
            for (int p = 0; p < FFR; p++) begin
                @(negedge clk);
                if (pwm1 === 1'b1) hi++;
                if (p == BI + BF + 999)  chk(pwm1, 1'b1, "R5");
                if (p == BI + BF + 1000) chk(pwm1, 1'b0, "R5");
                if (p == FFR - 1)        chk(pwm1, 1'b0, "R7");
            end
            total++;
            if (hi != BI + BF + 1000) begin
                bad++;
                $display("FAIL R2 actual=%0d expected=%0d high periods", hi, BI + BF + 1000);
            end
            @(negedge clk);
            chk(pwm1, 1'b1, "R2");   // next frame starts right after 4119 periods
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule